// File: doc/BRIEF.md
# Sequential Add-and-Shift Multiplier

This block multiplies two unsigned operands, 4 bits each by default, and returns a double-width product. It does not use an array of partial-product adders. It has one ripple adder and one shifting register. The upper half of that register is the accumulator. The lower half starts with the multiplier and gives up one bit for each product bit that shifts in.

Each multiplier bit costs two cycles. The add cycle adds the multiplicand into the accumulator, but only if the current low bit of the register is 1. The shift cycle then moves the whole register one place to the right. The adder's carry-out is held as an extra top bit and shifts down on that step, so no overflow is lost. A full multiply takes 2N steps.

A caller pulses `start` with the operands present and waits for the one-cycle `done` pulse. The product stays on the output until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `busy` at 0 and `done` at 0 after that edge.
- R2: With `busy` low, a `start` sampled high at a clock edge captures `opA` and `opB`, and `busy` is 1 after that same edge.
- R3: `busy` stays high for exactly 2×W clock cycles (8 for W = 4): one add step and one shift step per multiplier bit.
- R4: `done` is high for exactly one cycle. It rises on the same edge where `busy` falls.
- R5: While `done` is high, `product` equals the unsigned product of the captured operands as a 2×W-bit value. For example, 13×5 gives 65 (8'b01000001) and 10×3 gives 30 (8'b00011110).
- R6: Adder carries are never lost. The largest operands, 15×15, give 225, and the zero operands give 0.
- R7: A `start` pulse while `busy` is high has no effect: the running operation keeps its timing and its result.
- R8: After `done`, `product` holds its value until the next accepted `start`.
- R9: Changes on `opA`/`opB` while `busy` is high do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply when idle |
| opA | input | W | Multiplicand, unsigned |
| opB | input | W | Multiplier, unsigned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2×W | Unsigned product |

## Verification
A wrong step count or a wrong state transition changes the length of `busy` right away. It also shifts or repeats the `done` pulse, and both are seen on the cycle the operation ends. A wrong add condition, a dropped carry or a missing shift corrupts `product`. That shows at the `done` cycle of any operand pair that uses the broken path: odd multiplier bits for the add, large operands for the carry. A register that reloads wrongly during or after a run shows as a result built from mid-run operands, or as a product that drifts while idle. Both are caught on the first operation that touches them.

// File: rtl/mul_pkg.sv
`timescale 1ns/1ps
package mul_pkg;
  typedef struct packed {
    logic load;
    logic addStep;
    logic shiftStep;
  } mulStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2
  } mulState_t;
endpackage

// File: rtl/mul_adder.sv
`timescale 1ns/1ps
module mul_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carryOut
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign carryOut = carry[W];
endmodule

// File: rtl/mul_datapath.sv
`timescale 1ns/1ps
module mul_datapath
  import mul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  mulStrobes_t   strobe,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  output logic [2*W-1:0] product
);
  // accum holds the carry bit on top of the upper product half
  logic [W:0]   accum;
  logic [W-1:0] lowHalf;
  logic [W-1:0] mcand;
  logic [W-1:0] addSum;
  logic         addCarry;

  mul_adder #(.W(W)) u_adder (
    .a        (accum[W-1:0]),
    .b        (mcand),
    .sum      (addSum),
    .carryOut (addCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accum   <= '0;
      lowHalf <= '0;
      mcand   <= '0;
    end else if (strobe.load) begin
      accum   <= '0;
      lowHalf <= opB;
      mcand   <= opA;
    end else if (strobe.addStep) begin
      if (lowHalf[0]) accum <= {addCarry, addSum};
    end else if (strobe.shiftStep) begin
      accum   <= {1'b0, accum[W:1]};
      lowHalf <= {accum[0], lowHalf[W-1:1]};
    end
  end

  assign product = {accum[W-1:0], lowHalf};
endmodule

// File: rtl/mul_ctrl.sv
`timescale 1ns/1ps
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output mulStrobes_t strobe,
  output logic        busy,
  output logic        done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  mulState_t      state;
  logic [CW-1:0]  bitIdx;
  logic           lastBit;

  assign lastBit          = (bitIdx == CW'(W - 1));
  assign busy             = (state != ST_IDLE);
  assign strobe.load      = (state == ST_IDLE) && start;
  assign strobe.addStep   = (state == ST_ADD);
  assign strobe.shiftStep = (state == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_ADD;
            bitIdx <= '0;
          end
        end
        ST_ADD: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (lastBit) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state  <= ST_ADD;
            bitIdx <= bitIdx + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shift_add_mult.sv
`timescale 1ns/1ps
module shift_add_mult
  import mul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  mulStrobes_t strobe;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );
endmodule

// File: rtl/mul_checker.sv
`timescale 1ns/1ps
module mul_checker #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   opA,
  input logic [W-1:0]   opB,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int CNTW = $clog2(2 * W + 2) + 1;

  logic [CNTW-1:0] busyCnt;
  logic [W-1:0]    capA;
  logic [W-1:0]    capB;
  logic [2*W-1:0]  refProd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyCnt <= '0;
      capA    <= '0;
      capB    <= '0;
    end else if (start && !busy) begin
      busyCnt <= '0;
      capA    <= opA;
      capB    <= opB;
    end else if (busy) begin
      busyCnt <= busyCnt + CNTW'(1);
    end
  end

  assign refProd = {{W{1'b0}}, capA} * {{W{1'b0}}, capB};

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R2
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst) done |-> (busyCnt == CNTW'(2 * W))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_DONE_EDGE:  assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R4
  AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (rst) done |-> (product == refProd)); // R5
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(product)); // R8
endmodule

bind shift_add_mult mul_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .opA     (opA),
  .opB     (opB),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/shift_add_mult_bench.sv
`timescale 1ns/1ps
module shift_add_mult_bench;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   opA = '0;
  logic [W-1:0]   opB = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shift_add_mult #(.W(W)) u_shift_add_mult (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .product(product)
  );

  function automatic int expProd(input int a, input int b);
    return (a * b) & ((1 << (2 * W)) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: quiet run, 1: operands change mid-run (R9), 2: extra start mid-run (R7)
  task automatic runOp(input int a, input int b, input int mode);
    int cycles;
    logic [2*W-1:0] held;
    @(negedge clk);
    start = 1'b1; opA = W'(a); opB = W'(b);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    cycles = 0;
    while (!done && cycles < 40) begin
      if (busy) cycles++;
      if (cycles == 3 && mode != 0) begin
        opA   = ~W'(a);
        opB   = W'($urandom);
        start = (mode == 2);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(cycles == 2 * W, "R3 busy length", cycles, 2 * W);
    chk(done == 1'b1 && busy == 1'b0, "R4 done with busy low", int'({done, busy}), 2);
    if (mode == 2)
      chk(product == expProd(a, b), "R7 start while busy ignored", int'(product), expProd(a, b));
    else if (mode == 1)
      chk(product == expProd(a, b), "R9 mid-run operand change ignored", int'(product), expProd(a, b));
    else
      chk(product == expProd(a, b), "R5 product value", int'(product), expProd(a, b));
    held = product;
    opA = W'($urandom); opB = W'($urandom);
    @(negedge clk);
    chk(done == 1'b0, "R4 done single cycle", int'(done), 0);
    repeat (2) @(negedge clk);
    chk(product == held, "R8 product holds", int'(product), int'(held));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R1 reset state", int'({busy, done}), 0);

    runOp(13, 5, 0);
    chk(product == 8'd65, "R5 13x5", int'(product), 65);
    runOp(10, 3, 0);
    chk(product == 8'd30, "R5 10x3", int'(product), 30);
    runOp(15, 15, 0);
    chk(product == 8'd225, "R6 15x15 carry", int'(product), 225);
    runOp(0, 11, 0);
    chk(product == 8'd0, "R6 zero multiplicand", int'(product), 0);
    runOp(9, 0, 0);
    chk(product == 8'd0, "R6 zero multiplier", int'(product), 0);
    runOp(15, 8, 2);
    runOp(7, 15, 1);

    // reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; opA = 4'd6; opB = 4'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R1 reset mid-run", int'({busy, done}), 0);
    repeat (10) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R1 stays idle after reset", int'({busy, done}), 0);

    for (int n = 0; n < 60; n++) begin
      runOp(int'($urandom % 16), int'($urandom % 16), int'($urandom % 3));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule